// File: doc/BRIEF.md
# Flash Status Polling Controller

This block sits on the host side of a parallel flash device and waits for an internal program or erase operation to finish. Once the host has written the whole command sequence (four writes for a program, six for an erase), it pulses `start_i` with the expected byte, the operation kind, a sector address and a poll budget. The controller then issues status reads over a simple request and response port, always at the latched sector address, and judges each returned byte.

Bit 7 of a returned byte shows completion. For a program it must equal bit 7 of the expected byte, and for an erase it must be 1. Bit 5 set while bit 7 is still incomplete means the device has passed its internal time limit. The controller then makes exactly one more read to tell a late finish from a real failure. When bit 7 shows completion, the lower bits may not yet be valid. For that reason, success is only declared after a further confirming read. If the budget of polling reads runs out with neither completion nor a bit 5 report, the controller reports a timeout.

Top module: `flash_poll_ctrl`

## Requirements
- R1: A `start_i` pulse while idle latches the sector address, expected byte, operation kind and poll budget, and clears the outcome flags in the next cycle. A `start_i` pulse while busy has no effect on the running operation.
- R2: Every read request carries the sector address latched at start, and `rd_addr_o` stays constant for the whole operation.
- R3: For a program (`is_erase_i`=0), a polled byte counts as complete when its bit 7 equals bit 7 of the expected byte.
- R4: For an erase (`is_erase_i`=1), a polled byte counts as complete when its bit 7 is 1.
- R5: After a complete byte the controller always makes one confirming read. A program passes only if that byte equals the full expected byte. An erase passes only if its bit 7 is 1. Otherwise the result is fail.
- R6: A polled byte with bit 5 = 1 and bit 7 incomplete triggers exactly one extra read. If that byte is complete, the confirming read of R5 follows. If it is not complete, the controller reports fail.
- R7: If the last allowed polling read is incomplete with bit 5 = 0, the controller reports timeout after exactly `max_polls_i` polling reads. A budget of 0 behaves as 1.
- R8: `done_o` is a one-cycle pulse, and while it is high exactly one of `pass_o`, `fail_o` and `timeout_o` is 1.
- R9: The outcome flags keep their value after `done_o` until the next accepted start.
- R10: `rd_req_o` is held until `rd_valid_i` answers it, and it is low while the controller is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start polling (command sequence finished) |
| is_erase_i | input | 1 | 1 = erase operation, 0 = program operation |
| exp_data_i | input | DATA_W | Byte that was programmed |
| sector_addr_i | input | ADDR_W | Address inside the sector being polled |
| max_polls_i | input | CNT_W | Maximum number of polling reads |
| rd_req_o | output | 1 | Read request, held until answered |
| rd_addr_o | output | ADDR_W | Read address |
| rd_valid_i | input | 1 | Read response valid |
| rd_data_i | input | DATA_W | Read response byte |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| pass_o | output | 1 | Outcome: operation succeeded |
| fail_o | output | 1 | Outcome: device reported failure or confirm mismatch |
| timeout_o | output | 1 | Outcome: poll budget exhausted |

## Verification
On every cycle, the assertions check the following:
- the request handshake and address stability;
- that `done_o` is a single pulse carrying exactly one outcome flag, and that the flags hold while idle;
- that each outcome is reached only from its legal state: pass only from the confirming read, timeout only with the budget used up.

Only the bench scenarios can show that the right outcome comes from a given sequence of status bytes. They also show that the read count matches, including:
- the bit 5 recheck path;
- late completions;
- confirm mismatches;
- a zero budget;
- a start pulse that arrives mid-operation.

// File: rtl/flash_poll_pkg.sv
package flash_poll_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_READ    = 3'd1,
    ST_CHECK   = 3'd2,
    ST_RECHECK = 3'd3,
    ST_CONFIRM = 3'd4,
    ST_DONE    = 3'd5
  } poll_state_e;

  typedef enum logic [1:0] {
    RES_NONE    = 2'd0,
    RES_PASS    = 2'd1,
    RES_FAIL    = 2'd2,
    RES_TIMEOUT = 2'd3
  } poll_result_e;

endpackage

// File: rtl/poll_judge.sv
module poll_judge #(
  parameter int DATA_W    = 8,
  parameter int DONE_BIT  = 7,
  parameter int LIMIT_BIT = 5
) (
  input  logic [DATA_W-1:0] status_i,
  input  logic [DATA_W-1:0] expect_i,
  input  logic              erase_i,
  output logic              complete_o,
  output logic              limit_o,
  output logic              confirm_ok_o
);

  // Completion target for the done bit: erased cells read 1.
  function automatic logic done_target(input logic [DATA_W-1:0] exp, input logic erase);
    return erase ? 1'b1 : exp[DONE_BIT];
  endfunction

  function automatic logic is_complete(input logic [DATA_W-1:0] st,
                                       input logic [DATA_W-1:0] exp,
                                       input logic erase);
    return st[DONE_BIT] == done_target(exp, erase);
  endfunction

  // Final byte check: program needs the whole byte, erase the done bit.
  function automatic logic confirm_match(input logic [DATA_W-1:0] st,
                                         input logic [DATA_W-1:0] exp,
                                         input logic erase);
    return erase ? st[DONE_BIT] : (st == exp);
  endfunction

  assign complete_o   = is_complete(status_i, expect_i, erase_i);
  assign limit_o      = status_i[LIMIT_BIT];
  assign confirm_ok_o = confirm_match(status_i, expect_i, erase_i);

endmodule

// File: rtl/poll_budget.sv
module poll_budget #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_i,
  input  logic [CNT_W-1:0] max_i,
  input  logic             bump_i,
  output logic             exhausted_o
);

  logic [CNT_W-1:0] max_q;
  logic [CNT_W-1:0] count_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      max_q   <= '0;
      count_q <= '0;
    end else if (clear_i) begin
      max_q   <= max_i;
      count_q <= '0;
    end else if (bump_i && count_q != {CNT_W{1'b1}}) begin
      count_q <= count_q + 1'b1;
    end
  end

  // A zero budget still allows one read: count 1 >= 0.
  assign exhausted_o = (count_q >= max_q);

  // R7: the counter never runs past the budget, except one read for budget 0.
  assert_budget_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (count_q > max_q) |-> (max_q == '0 && count_q == 1));

endmodule

// File: rtl/flash_poll_ctrl.sv
module flash_poll_ctrl
  import flash_poll_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int ADDR_W    = 18,
  parameter int CNT_W     = 16,
  parameter int DONE_BIT  = 7,
  parameter int LIMIT_BIT = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              is_erase_i,
  input  logic [DATA_W-1:0] exp_data_i,
  input  logic [ADDR_W-1:0] sector_addr_i,
  input  logic [CNT_W-1:0]  max_polls_i,
  output logic              rd_req_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic              rd_valid_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              pass_o,
  output logic              fail_o,
  output logic              timeout_o
);

  localparam int JUDGE_N   = 2;
  localparam int J_LIVE    = 0;
  localparam int J_STORED  = 1;

  poll_state_e       state_q, state_d;
  poll_result_e      result_d;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] exp_q;
  logic              erase_q;
  logic [DATA_W-1:0] sample_q;
  logic              pass_q, fail_q, tmo_q;

  // Named internal events
  logic start_take;
  logic resp_take;
  logic poll_bump;
  logic exhausted;

  logic [JUDGE_N-1:0][DATA_W-1:0] judge_in;
  logic [JUDGE_N-1:0]             j_complete;
  logic [JUDGE_N-1:0]             j_limit;
  logic [JUDGE_N-1:0]             j_confirm;

  assign start_take = (state_q == ST_IDLE) && start_i;
  assign rd_req_o   = (state_q == ST_READ) || (state_q == ST_RECHECK) ||
                      (state_q == ST_CONFIRM);
  assign resp_take  = rd_req_o && rd_valid_i;
  assign poll_bump  = (state_q == ST_READ) && resp_take;

  assign judge_in[J_LIVE]   = rd_data_i;
  assign judge_in[J_STORED] = sample_q;

  // One judge on the live response, one on the stored polling byte.
  for (genvar g = 0; g < JUDGE_N; g++) begin : g_judge
    poll_judge #(
      .DATA_W   (DATA_W),
      .DONE_BIT (DONE_BIT),
      .LIMIT_BIT(LIMIT_BIT)
    ) u_judge (
      .status_i    (judge_in[g]),
      .expect_i    (exp_q),
      .erase_i     (erase_q),
      .complete_o  (j_complete[g]),
      .limit_o     (j_limit[g]),
      .confirm_ok_o(j_confirm[g])
    );
  end

  poll_budget #(.CNT_W(CNT_W)) u_budget (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear_i    (start_take),
    .max_i      (max_polls_i),
    .bump_i     (poll_bump),
    .exhausted_o(exhausted)
  );

  always_comb begin
    state_d  = state_q;
    result_d = RES_NONE;
    unique case (state_q)
      ST_IDLE: if (start_i) state_d = ST_READ;
      ST_READ: if (resp_take) state_d = ST_CHECK;
      ST_CHECK: begin
        if (j_complete[J_STORED]) begin
          state_d = ST_CONFIRM;
        end else if (j_limit[J_STORED]) begin
          state_d = ST_RECHECK;
        end else if (exhausted) begin
          state_d  = ST_DONE;
          result_d = RES_TIMEOUT;
        end else begin
          state_d = ST_READ;
        end
      end
      ST_RECHECK: begin
        if (resp_take) begin
          if (j_complete[J_LIVE]) begin
            state_d = ST_CONFIRM;
          end else begin
            state_d  = ST_DONE;
            result_d = RES_FAIL;
          end
        end
      end
      ST_CONFIRM: begin
        if (resp_take) begin
          state_d  = ST_DONE;
          result_d = j_confirm[J_LIVE] ? RES_PASS : RES_FAIL;
        end
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      addr_q   <= '0;
      exp_q    <= '0;
      erase_q  <= 1'b0;
      sample_q <= '0;
      pass_q   <= 1'b0;
      fail_q   <= 1'b0;
      tmo_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      if (start_take) begin
        addr_q  <= sector_addr_i;
        exp_q   <= exp_data_i;
        erase_q <= is_erase_i;
        pass_q  <= 1'b0;
        fail_q  <= 1'b0;
        tmo_q   <= 1'b0;
      end
      if (poll_bump) sample_q <= rd_data_i;
      if (result_d == RES_PASS)    pass_q <= 1'b1;
      if (result_d == RES_FAIL)    fail_q <= 1'b1;
      if (result_d == RES_TIMEOUT) tmo_q  <= 1'b1;
    end
  end

  assign rd_addr_o = addr_q;
  assign busy_o    = (state_q != ST_IDLE);
  assign done_o    = (state_q == ST_DONE);
  assign pass_o    = pass_q;
  assign fail_o    = fail_q;
  assign timeout_o = tmo_q;

  // ---------------- assertions ----------------
  assert_addr_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o)) |-> $stable(rd_addr_o));

  assert_req_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_o && !rd_valid_i) |=> rd_req_o);

  assert_no_req_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !rd_req_o);

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_one_outcome_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> ($countones({pass_o, fail_o, timeout_o}) == 1));

  assert_status_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && $past(!busy_o)) |-> $stable({pass_o, fail_o, timeout_o}));

  assert_pass_after_confirm_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pass_o) |-> $past(state_q == ST_CONFIRM));

  assert_fail_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fail_o) |-> $past(state_q == ST_CONFIRM || state_q == ST_RECHECK));

  assert_timeout_budget_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeout_o) |-> $past(state_q == ST_CHECK && exhausted));

  assert_start_busy_ignored_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && busy_o && state_q != ST_DONE) |=> busy_o);

endmodule

// File: tb/flash_poll_ctrl_tb.sv
module flash_poll_ctrl_tb;

  localparam int DW = 8;
  localparam int AW = 18;
  localparam int CW = 16;
  localparam int SEQ_N = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_i = 1'b0;
  logic          is_erase_i = 1'b0;
  logic [DW-1:0] exp_data_i = '0;
  logic [AW-1:0] sector_addr_i = '0;
  logic [CW-1:0] max_polls_i = '0;
  logic          rd_req_o;
  logic [AW-1:0] rd_addr_o;
  logic          rd_valid_i = 1'b0;
  logic [DW-1:0] rd_data_i = '0;
  logic          busy_o, done_o, pass_o, fail_o, timeout_o;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  logic [DW-1:0] seq [SEQ_N];
  int            seq_idx = 0;
  int            reads = 0;
  int            addr_err = 0;
  int            done_cnt = 0;
  int            lat = 0;
  logic [AW-1:0] cur_addr = '0;

  always #5 clk = ~clk;

  flash_poll_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .is_erase_i(is_erase_i),
    .exp_data_i(exp_data_i), .sector_addr_i(sector_addr_i), .max_polls_i(max_polls_i),
    .rd_req_o(rd_req_o), .rd_addr_o(rd_addr_o), .rd_valid_i(rd_valid_i),
    .rd_data_i(rd_data_i), .busy_o(busy_o), .done_o(done_o), .pass_o(pass_o),
    .fail_o(fail_o), .timeout_o(timeout_o)
  );

  // Flash responder: answers held requests after 0..2 cycles of latency.
  always @(negedge clk) begin
    automatic logic was_valid = rd_valid_i;
    rd_valid_i = 1'b0;
    if (done_o) done_cnt++;
    if (rd_req_o && !was_valid) begin
      if (lat == 0) begin
        rd_valid_i = 1'b1;
        rd_data_i  = seq[(seq_idx < SEQ_N) ? seq_idx : SEQ_N-1];
        seq_idx++;
        reads++;
        if (rd_addr_o !== cur_addr) addr_err++;
        lat = $urandom % 3;
      end else begin
        lat--;
      end
    end
  end

  task automatic check(input string req, input int act, input int exp, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Reference model: 1 pass, 2 fail, 3 timeout
  function automatic int model(input bit erase, input logic [DW-1:0] exp,
                               input int mx, output int nreads);
    int i = 0;
    int polls = 0;
    logic [DW-1:0] b;
    bit tgt = erase ? 1'b1 : exp[7];
    bit go_confirm = 0;
    int lim = (mx == 0) ? 1 : mx;
    while (!go_confirm) begin
      b = seq[i]; i++; polls++;
      if (b[7] == tgt) go_confirm = 1;
      else if (b[5]) begin
        b = seq[i]; i++;
        if (b[7] == tgt) go_confirm = 1;
        else begin nreads = i; return 2; end
      end else if (polls >= lim) begin
        nreads = i; return 3;
      end
    end
    b = seq[i]; i++;
    nreads = i;
    if (erase) return b[7] ? 1 : 2;
    return (b == exp) ? 1 : 2;
  endfunction

  function automatic int outcome();
    return pass_o ? 1 : (fail_o ? 2 : (timeout_o ? 3 : 0));
  endfunction

  task automatic run_op(input string req, input bit erase, input logic [DW-1:0] exp,
                        input logic [AW-1:0] addr, input int mx, input bit mid_start);
    int exp_res, exp_reads;
    exp_res = model(erase, exp, mx, exp_reads);
    seq_idx = 0; reads = 0; addr_err = 0; done_cnt = 0;
    cur_addr = addr;
    @(negedge clk);
    is_erase_i = erase; exp_data_i = exp; sector_addr_i = addr;
    max_polls_i = CW'(mx); start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    // R1: flags cleared the cycle after an accepted start
    check("R1", {29'd0, pass_o, fail_o, timeout_o}, 0, "flags cleared at start");
    check("R1", busy_o, 1, "busy after start");
    if (mid_start) begin
      repeat (2) @(negedge clk);
      sector_addr_i = ~addr; is_erase_i = ~erase; exp_data_i = ~exp; max_polls_i = '0;
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
    end
    while (!done_o) @(negedge clk);
    check(req, outcome(), exp_res, "outcome");
    check(req, reads, exp_reads, "read count");
    check("R2", addr_err, 0, "reads off sector address");
    check("R8", $countones({pass_o, fail_o, timeout_o}), 1, "one flag with done");
    @(negedge clk);
    check("R8", done_o, 0, "done one cycle");
    repeat (4) @(negedge clk);
    check("R9", outcome(), exp_res, "flags held while idle");
    check("R8", done_cnt, 1, "done pulse count");
    check("R10", rd_req_o, 0, "no request when idle");
  endtask

  task automatic fill(input logic [DW-1:0] v);
    for (int i = 0; i < SEQ_N; i++) seq[i] = v;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    fill(8'h80);
    repeat (3) @(negedge clk);
    check("R10", rd_req_o, 0, "reset request");
    check("R8", {28'd0, busy_o, pass_o, fail_o, timeout_o}, 0, "reset outputs");
    rst_n = 1'b1;
    @(negedge clk);

    // R3 program: 80 incomplete (bit7 1 vs 0), 1F complete, 5A confirm -> pass
    fill(8'h80); seq[2] = 8'h1F; seq[3] = 8'h5A;
    run_op("R3", 1'b0, 8'h5A, 18'h12345, 8, 1'b0);
    // R5 confirm mismatch -> fail
    fill(8'h1F); seq[0] = 8'h80;
    run_op("R5", 1'b0, 8'h5A, 18'h00F00, 8, 1'b0);
    // R6 bit5 then complete -> confirm -> pass
    fill(8'h80); seq[1] = 8'hA0; seq[2] = 8'h00; seq[3] = 8'h5A;
    run_op("R6", 1'b0, 8'h5A, 18'h2AAAA, 8, 1'b0);
    // R6 bit5 then still incomplete -> fail
    fill(8'hA0); seq[0] = 8'h80;
    run_op("R6", 1'b0, 8'h5A, 18'h15555, 8, 1'b0);
    // R7 budget of 3 -> timeout after 3 reads
    fill(8'h80);
    run_op("R7", 1'b0, 8'h5A, 18'h00001, 3, 1'b0);
    // R7 budget 0 behaves as 1
    fill(8'h80);
    run_op("R7", 1'b0, 8'h5A, 18'h00002, 0, 1'b0);
    // R4 erase: 00 incomplete, 80 complete, FF confirm -> pass
    fill(8'hFF); seq[0] = 8'h00; seq[1] = 8'h00; seq[2] = 8'h80;
    run_op("R4", 1'b1, 8'h00, 18'h30000, 8, 1'b0);
    // R5 erase confirm with bit7 0 -> fail
    fill(8'h7F); seq[0] = 8'h00; seq[1] = 8'h80;
    run_op("R5", 1'b1, 8'h00, 18'h30001, 8, 1'b0);
    // R1 start while busy ignored
    fill(8'h80); seq[4] = 8'h1F; seq[5] = 8'h5A;
    run_op("R1", 1'b0, 8'h5A, 18'h0ABCD, 8, 1'b1);

    // Constrained random operations
    for (int n = 0; n < 40; n++) begin
      automatic bit erase = $urandom % 2;
      automatic logic [DW-1:0] exp = DW'($urandom);
      automatic bit tgt = erase ? 1'b1 : exp[7];
      automatic int mx = $urandom % 9;
      for (int i = 0; i < SEQ_N; i++) begin
        automatic int r = $urandom % 10;
        automatic logic [DW-1:0] b = DW'($urandom);
        if (r < 6) begin b[7] = ~tgt; b[5] = 1'b0; end
        else if (r == 6) b[7] = tgt;
        else if (r == 7) begin b[7] = ~tgt; b[5] = 1'b1; end
        else if (r == 8) b = exp;
        seq[i] = b;
      end
      run_op(erase ? "R4" : "R3", erase, exp, AW'($urandom), mx, 1'b0);
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule